// File: doc/BRIEF.md
# Serial Configuration Latch Port

This block receives configuration words for a frequency synthesizer over a three-line serial link made of a serial clock, a serial data line and a load strobe. Bits enter a 24-bit shift register on each rising edge of the serial clock, most significant bit first. The two bits shifted in last form a destination code. When the load strobe rises, the upper 22 bits of the shift register are copied into the configuration register that the code selects. There are four such registers.

All three serial lines and the chip-enable input are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected in the system-clock domain. Each configuration register has a one-cycle update strobe, so downstream logic can react to a fresh word. A low chip-enable input drives a power-down status output. Interpreting the individual fields of the registers is left to the consumers.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, all four 22-bit register outputs are zero, no update strobe is high, and `pwr_down_o` is 1 while `chip_en_i` is low.
- R2: One data bit is taken on each rising edge of `ser_clk_i`, most significant bit first. Only the last 24 bits shifted before a load count, so leading bits of a longer stream are dropped.
- R3: A rising edge of `ser_ld_i` copies shift-register bits 23..2 into register k, where k is the value of bits 1..0. Register k appears on `cfg_o[k*22 +: 22]`. The other three registers keep their values.
- R4: Each transfer pulses `upd_o[k]` for exactly one system clock, and only for the selected register. At most one strobe bit is high at a time.
- R5: Holding `ser_ld_i` high for many cycles performs exactly one transfer.
- R6: Rising edges of `ser_clk_i` while `ser_ld_i` is high do not shift the register.
- R7: `pwr_down_o` equals the inverse of `chip_en_i`, and follows it on the third rising system-clock edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_i | input | 1 | Load strobe, transfer on rising edge |
| chip_en_i | input | 1 | Chip enable, low requests power-down |
| cfg_o | output | 88 | Four 22-bit registers, register k at bits k*22 +: 22 |
| upd_o | output | 4 | One-cycle update strobe per register |
| pwr_down_o | output | 1 | Power-down status |

## Verification
The bench sends words to every destination code with all-ones, all-zeros, alternating and computed payloads. After each word it compares all four registers, so a decoder that wrote two registers, or wrote the wrong one, shows up as a changed neighbour or a wrong strobe count. A long load pulse catches a level-triggered transfer, which would repeat its strobe. Serial clock edges during a held load catch a shifter that is not gated: the following reload would land in a different register. A 30-bit stream shows whether stale leading bits leak into the word. The chip-enable latency is sampled on both sides of the third edge to expose a missing or extra synchronizer stage.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    // Registered edge and status state of the front end
    typedef struct packed {
        logic sclk_prev;
        logic ld_prev;
        logic pd;
    } front_t;

    localparam front_t FRONT_RST = '{sclk_prev: 1'b0, ld_prev: 1'b0, pd: 1'b1};

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word_o = sr_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
    parameter int unsigned PAY_W = 22,
    parameter int unsigned SEL_W = 2,
    localparam int unsigned NUM  = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SEL_W-1:0]   sel,
    input  logic [PAY_W-1:0]   pay_in,
    output logic [NUM*PAY_W-1:0] pay_o,
    output logic [NUM-1:0]     stb_o
);
    for (genvar k = 0; k < NUM; k++) begin : g_reg
        logic [PAY_W-1:0] reg_d, reg_q;
        logic             stb_d, stb_q;
        logic             hit;

        assign hit = load && (sel == SEL_W'(k));

        always_comb begin
            reg_d = hit ? pay_in : reg_q;
            stb_d = hit;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= '0;
                stb_q <= 1'b0;
            end else begin
                reg_q <= reg_d;
                stb_q <= stb_d;
            end
        end

        assign pay_o[k*PAY_W +: PAY_W] = reg_q;
        assign stb_o[k]                = stb_q;
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int unsigned WORD_W      = 24,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_LATCH  = 1 << SEL_W,
    localparam int unsigned PAY_W      = WORD_W - SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    input  logic                       ser_ld_i,
    input  logic                       chip_en_i,
    output logic [NUM_LATCH*PAY_W-1:0] cfg_o,
    output logic [NUM_LATCH-1:0]       upd_o,
    output logic                       pwr_down_o
);
    import cfg_port_pkg::*;

    logic [3:0]        raw_in, sync_out;
    logic              sclk_s, dat_s, ld_s, ce_s;
    logic              sclk_rise, ld_rise, shift_en;
    logic [WORD_W-1:0] word;
    front_t            st_d, st_q;

    assign raw_in = {chip_en_i, ser_ld_i, ser_dat_i, ser_clk_i};

    cfg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign {ce_s, ld_s, dat_s, sclk_s} = sync_out;

    // Edge detection in the system-clock domain; shifting frozen while load is high
    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign ld_rise   = ld_s & ~st_q.ld_prev;
    assign shift_en  = sclk_rise & ~ld_s;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.ld_prev   = ld_s;
        st_d.pd        = ~ce_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRONT_RST;
        else        st_q <= st_d;
    end

    cfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (dat_s),
        .word_o  (word)
    );

    cfg_latch_bank #(.PAY_W(PAY_W), .SEL_W(SEL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_rise),
        .sel   (word[SEL_W-1:0]),
        .pay_in(word[WORD_W-1:SEL_W]),
        .pay_o (cfg_o),
        .stb_o (upd_o)
    );

    assign pwr_down_o = st_q.pd;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int unsigned NUM   = 4,
    parameter int unsigned PAY_W = 22
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ld_rise,
    input logic                 ce_s,
    input logic [NUM*PAY_W-1:0] cfg_o,
    input logic [NUM-1:0]       upd_o,
    input logic                 pwr_down_o
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o)); // R4
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_o) |=> !(|upd_o)); // R5
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_o) |-> $past(ld_rise)); // R3
    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|upd_o) |-> $stable(cfg_o)); // R3
    AST_PD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> pwr_down_o); // R7
    AST_PD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |=> !pwr_down_o); // R7
endmodule

bind serial_cfg_port cfg_port_chk #(.NUM(NUM_LATCH), .PAY_W(PAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_rise   (ld_rise),
    .ce_s      (ce_s),
    .cfg_o     (cfg_o),
    .upd_o     (upd_o),
    .pwr_down_o(pwr_down_o)
);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdat = 1'b0, sld = 1'b0, ce = 1'b0;
    logic [87:0] cfg;
    logic [3:0]  upd;
    logic        pd;

    int checks = 0;
    int fails  = 0;
    int scount [4] = '{0, 0, 0, 0};
    int snap   [4];
    logic [21:0] model [4] = '{22'd0, 22'd0, 22'd0, 22'd0};
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_ld_i(sld), .chip_en_i(ce), .cfg_o(cfg), .upd_o(upd), .pwr_down_o(pd)
    );

    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) if (upd[k]) scount[k]++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic ld_pulse(input int hold);
        repeat (3) @(negedge clk);
        sld = 1'b1;
        repeat (hold) @(negedge clk);
        sld = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic take_snap();
        for (int k = 0; k < 4; k++) snap[k] = scount[k];
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 4; k++) chk(req, 32'(cfg[k*22 +: 22]), 32'(model[k]));
    endtask

    task automatic check_strobes(input string req, input int sel);
        for (int k = 0; k < 4; k++)
            chk(req, 32'(scount[k] - snap[k]), (k == sel) ? 32'd1 : 32'd0);
    endtask

    function automatic logic [21:0] pattern(input int s, input int j);
        case (j)
            0: return 22'h3FFFFF;
            1: return 22'h000000;
            2: return 22'h2AAAAA;
            default: return (22'h15A3C ^ 22'(j * 22'h0F1E3)) + 22'(s * 22'h40001);
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_regs("R1");
        chk("R1 strobe", 32'(upd), 32'd0);
        chk("R1 pd", 32'(pd), 32'd1);

        // R7: chip enable rise, latency of three edges
        ce = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 early", 32'(pd), 32'd1);
        @(negedge clk);
        chk("R7 rise", 32'(pd), 32'd0);

        // R2 R3 R4: sweep every destination with several payloads
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 6; j++) begin
                logic [21:0] p;
                p = pattern(s, j);
                take_snap();
                send_bits(64'({p, 2'(s)}), 24);
                ld_pulse(4);
                model[s] = p;
                check_regs("R3");
                check_strobes("R4", s);
            end
        end

        // R5: long load pulse transfers once
        take_snap();
        send_bits(64'({22'h1357AC, 2'd2}), 24);
        ld_pulse(40);
        model[2] = 22'h1357AC;
        check_regs("R5");
        check_strobes("R5", 2);

        // R6: clock edges during held load must not shift
        take_snap();
        send_bits(64'({22'h0BEEF1, 2'd1}), 24);
        repeat (3) @(negedge clk);
        sld = 1'b1;
        repeat (4) @(negedge clk);
        send_bits(64'b10, 2);
        sld = 1'b0;
        repeat (6) @(negedge clk);
        model[1] = 22'h0BEEF1;
        check_regs("R6 first");
        take_snap();
        ld_pulse(4);
        check_regs("R6 reload");
        check_strobes("R6", 1);

        // R2: 30-bit stream, leading six bits dropped
        take_snap();
        send_bits({28'd0, 6'b111111, 22'h05C0DE, 2'd3}, 30);
        ld_pulse(4);
        model[3] = 22'h05C0DE;
        check_regs("R2");
        check_strobes("R2", 3);

        // R7: chip enable fall
        ce = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 early fall", 32'(pd), 32'd0);
        @(negedge clk);
        chk("R7 fall", 32'(pd), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule